// File: doc/BRIEF.md
# Serial identification EEPROM slave

This block is a two-wire serial EEPROM slave that holds 256 read-only bytes describing a memory module. A master bit-bangs the bus, and every write of its pin pair is handed to the block as one update strobe carrying the new clock and data levels. The block returns the data level it drives, which is the master's level, the slave's acknowledge, or a read data bit. The block has no clock of its own on the bus. Each strobe is one discrete step.

A transaction opens with a START. The master then sends a command byte whose least significant bit selects read (1) or write (0), and the slave acknowledges it. The master next sends an address byte. In read mode the slave shifts out, during that byte, the byte it loaded in the previous transaction. When the address byte completes, the slave latches the addressed byte, acknowledges, and waits for the next START. Storage is a fixed table and cannot be written.

Top module: `serial_id_eeprom`

## Requirements
- R1: After reset, sda_o is 1 and the held data byte is 0x00, so the first read address phase returns eight 0 bits.
- R2: While no transaction is open and no acknowledge is pending, updates other than a START cause no acknowledge and no forced level. sda_o simply follows sda_i on each update.
- R3: A falling SDA while SCL stays high (scl 1 to 1, sda 1 to 0) is a START. It restarts command collection at the first bit, even in the middle of a transaction.
- R4: Command bits are taken MSB-first on SCL rising edges where SDA is unchanged. The first SCL rising edge after the 8th command bit returns sda_o = 0 (acknowledge), whatever sda_i is.
- R5: An update in which SCL rises and SDA changes at the same time is ignored. No bit is taken, and sda_o shows the new sda_i.
- R6: When the command LSB is 1 (read), on each of the 8 address-bit rising edges sda_o carries the next bit of the held data byte, MSB first.
- R7: When the command LSB is 0 (write), on the address-bit rising edges sda_o follows sda_i.
- R8: After the 8th address bit the byte at that address becomes the held data byte. The next SCL rising edge returns sda_o = 0 (acknowledge), and then the slave waits for a START. A rising SDA while SCL stays high (STOP) changes nothing.
- R9: The table holds, among others, 0x80 at 0x00, 0x04 at 0x02, 0x0D at 0x03, 0x75 at 0x09, 0x12 at 0x3E, 0xF4 at 0x7F, and 0x00 at 0x80 and above.
- R10: sda_o changes only in the cycle after an update strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | One-cycle strobe: the master has written new pin levels |
| scl_i | input | 1 | Clock level written by the master |
| sda_i | input | 1 | Data level written by the master |
| sda_o | output | 1 | Data level returned by the slave |

## Verification
A wrong bit counter moves the acknowledge slot. The error then appears as a 0 on sda_o at the wrong rising edge, or as a missing 0 where one is expected, within the same transaction. A wrong shift direction, a wrong load point or a wrong table entry does not corrupt the transaction that loads the byte. It appears in the read address phase of the following transaction, which replays the held byte bit by bit. For this reason every transaction is followed by a read. Every update is compared against a queued expected level.

// File: rtl/sid_pkg.sv
package sid_pkg;

  // module identification table; entries not listed read as zero
  function automatic logic [7:0] id_byte(input int unsigned idx);
    case (idx)
      32'h00: id_byte = 8'h80;
      32'h01: id_byte = 8'h08;
      32'h02: id_byte = 8'h04;
      32'h03: id_byte = 8'h0D;
      32'h04: id_byte = 8'h0A;
      32'h05: id_byte = 8'h01;
      32'h06: id_byte = 8'h40;
      32'h08: id_byte = 8'h01;
      32'h09: id_byte = 8'h75;
      32'h0A: id_byte = 8'h54;
      32'h0C: id_byte = 8'h82;
      32'h0D: id_byte = 8'h08;
      32'h0F: id_byte = 8'h01;
      32'h10: id_byte = 8'h8F;
      32'h11: id_byte = 8'h04;
      32'h12: id_byte = 8'h02;
      32'h13: id_byte = 8'h01;
      32'h14: id_byte = 8'h01;
      32'h16: id_byte = 8'h0E;
      32'h1B: id_byte = 8'h14;
      32'h1C: id_byte = 8'h0F;
      32'h1D: id_byte = 8'h14;
      32'h1E: id_byte = 8'h2D;
      32'h1F: id_byte = 8'h40;
      32'h20: id_byte = 8'h15;
      32'h21: id_byte = 8'h08;
      32'h22: id_byte = 8'h15;
      32'h23: id_byte = 8'h08;
      32'h3E: id_byte = 8'h12;
      32'h3F: id_byte = 8'hD0;
      32'h7E: id_byte = 8'h64;
      32'h7F: id_byte = 8'hF4;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sid_bus_cond.sv
module sid_bus_cond (
  input  logic scl_q_i,
  input  logic sda_q_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic cond_o,
  output logic start_o,
  output logic rise_o,
  output logic hold_o
);
  // sda moving under a steady high scl is a bus condition
  assign cond_o  = scl_q_i & scl_i & (sda_q_i ^ sda_i);
  assign start_o = cond_o & ~sda_i;
  assign rise_o  = ~scl_q_i & scl_i;
  assign hold_o  = ~(sda_q_i ^ sda_i);
endmodule

// File: rtl/sid_rom.sv
module sid_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0] raw;
  assign raw = sid_pkg::id_byte(32'(addr_i));

  generate
    if (DATA_W >= 8) begin : g_wide
      assign data_o = DATA_W'(raw);
    end else begin : g_narrow
      assign data_o = raw[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/serial_id_eeprom.sv
module serial_id_eeprom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CMD_W  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  localparam int CMD_END = CMD_W + 1;
  localparam int ADR_END = CMD_END + ADDR_W;
  localparam int TICK_W  = $clog2(ADR_END + 1);
  localparam logic [TICK_W-1:0] T_CMD_END = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] T_ADR_END = TICK_W'(ADR_END);
  localparam logic [TICK_W-1:0] T_ONE     = TICK_W'(1);

  logic              scl_q, sda_q, ack_q;
  logic [TICK_W-1:0] tick_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic              scl_d, sda_d, ack_d;
  logic [TICK_W-1:0] tick_d;
  logic [CMD_W-1:0]  cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  logic cond, start, rise, hold;
  logic [DATA_W-1:0] rom_data;

  sid_bus_cond u_cond (
    .scl_q_i (scl_q),
    .sda_q_i (sda_q),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .cond_o  (cond),
    .start_o (start),
    .rise_o  (rise),
    .hold_o  (hold)
  );

  sid_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .addr_i (addr_d),
    .data_o (rom_data)
  );

  always_comb begin
    scl_d  = scl_q;
    sda_d  = sda_q;
    ack_d  = ack_q;
    tick_d = tick_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    if (upd_i) begin
      scl_d = scl_i;
      sda_d = sda_i;
      if (cond) begin
        if (start) begin
          tick_d = T_ONE;
          cmd_d  = '0;
        end
      end else if (tick_q == '0 && !ack_q) begin
        // idle until START
      end else if (rise) begin
        if (ack_q) begin
          sda_d = 1'b0;
          ack_d = 1'b0;
        end else if (hold) begin
          if (tick_q < T_CMD_END) begin
            cmd_d  = {cmd_q[CMD_W-2:0], sda_i};
            tick_d = tick_q + T_ONE;
            if (tick_q == T_CMD_END - T_ONE) ack_d = 1'b1;
          end else if (tick_q < T_ADR_END) begin
            if (cmd_q[0]) sda_d = data_q[DATA_W-1];
            addr_d = {addr_q[ADDR_W-2:0], sda_i};
            if (tick_q == T_ADR_END - T_ONE) begin
              data_d = rom_data;
              ack_d  = 1'b1;
              tick_d = '0;
            end else begin
              data_d = {data_q[DATA_W-2:0], 1'b0};
              tick_d = tick_q + T_ONE;
            end
          end else begin
            sda_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      ack_q  <= 1'b0;
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      ack_q  <= ack_d;
      tick_q <= tick_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign sda_o = sda_q;
endmodule

// File: rtl/serial_id_eeprom_chk.sv
module serial_id_eeprom_chk #(
  parameter int TICK_W = 5,
  parameter int CMD_W  = 8,
  parameter int LAST_TICK = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_o,
  input logic              scl_q,
  input logic              sda_q,
  input logic              ack_q,
  input logic [TICK_W-1:0] tick_q,
  input logic [CMD_W-1:0]  cmd_q
);
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(sda_o));

  // R3
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && scl_q && scl_i && sda_q && !sda_i |=> tick_q == TICK_W'(1) && cmd_q == '0);

  // R2
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && tick_q == '0 && !ack_q && !(scl_q && scl_i && sda_q && !sda_i)
    |=> tick_q == '0 && !ack_q);

  // R4
  ack_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !scl_q && scl_i && ack_q |=> !sda_o && !ack_q);

  // R5
  skew_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !scl_q && scl_i && !ack_q && tick_q != '0 && (sda_i != sda_q)
    |=> $stable(tick_q));

  // R8
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q <= TICK_W'(LAST_TICK));
endmodule

bind serial_id_eeprom serial_id_eeprom_chk #(
  .TICK_W    (TICK_W),
  .CMD_W     (CMD_W),
  .LAST_TICK (ADR_END - 1)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .upd_i  (upd_i),
  .scl_i  (scl_i),
  .sda_i  (sda_i),
  .sda_o  (sda_o),
  .scl_q  (scl_q),
  .sda_q  (sda_q),
  .ack_q  (ack_q),
  .tick_q (tick_q),
  .cmd_q  (cmd_q)
);

// File: tb/serial_id_eeprom_test.sv
module serial_id_eeprom_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_i = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic sda_o;

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;
  logic last_out = 1'b1;

  typedef struct {
    logic  exp;
    string req;
  } item_t;
  item_t exp_q[$];

  always #5 clk_i = ~clk_i;

  serial_id_eeprom uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_o  (sda_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s sda_o actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: queue the expected level, then present one pin write
  task automatic pin(input logic s, input logic d, input logic e, input string req);
    item_t it;
    it.exp = e;
    it.req = req;
    exp_q.push_back(it);
    @(negedge clk_i);
    scl_i = s;
    sda_i = d;
    upd_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0;
    @(negedge clk_i);
  endtask

  // monitor: compare result of every update, check hold otherwise
  always begin
    @(posedge clk_i);
    #1;
    if (rst_ni && armed) begin
      if (upd_i) begin
        if (exp_q.size() == 0) begin
          check(1'bx, 1'b0, "queue");
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(sda_o, it.exp, it.req);
        end
        last_out = sda_o;
      end else begin
        check(sda_o, last_out, "R10");
      end
    end
  end

  // one transaction; rd_exp is the held byte the read address phase replays
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr,
                      input logic [7:0] rd_exp, input string rd_req,
                      input bit do_start, input bit glitch);
    if (do_start) pin(1'b1, 1'b0, 1'b0, "R3");
    for (int i = 7; i >= 0; i--) begin
      if (glitch) begin
        pin(1'b0, 1'b1, 1'b1, "R5");
        pin(1'b1, 1'b0, 1'b0, "R5");
      end
      pin(1'b0, cmd[i], cmd[i], "R4");
      pin(1'b1, cmd[i], cmd[i], "R4");
    end
    pin(1'b0, 1'b1, 1'b1, "R4");
    pin(1'b1, 1'b1, 1'b0, "R4");
    for (int i = 7; i >= 0; i--) begin
      pin(1'b0, adr[i], adr[i], "R7");
      if (cmd[0]) pin(1'b1, adr[i], rd_exp[i], rd_req);
      else        pin(1'b1, adr[i], adr[i], "R7");
    end
    pin(1'b0, 1'b1, 1'b1, "R8");
    pin(1'b1, 1'b1, 1'b0, "R8");
    pin(1'b1, 1'b1, 1'b1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(sda_o, 1'b1, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(sda_o, 1'b1, "R1");
    armed = 1'b1;

    // R2: activity before any START
    pin(1'b0, 1'b0, 1'b0, "R2");
    pin(1'b1, 1'b0, 1'b0, "R2");
    pin(1'b0, 1'b1, 1'b1, "R2");
    pin(1'b1, 1'b1, 1'b1, "R2");
    pin(1'b0, 1'b0, 1'b0, "R2");
    pin(1'b1, 1'b1, 1'b1, "R2");

    xfer(8'hA1, 8'h00, 8'h00, "R1", 1'b1, 1'b0);
    xfer(8'hA1, 8'h7F, 8'h80, "R9", 1'b1, 1'b0);
    xfer(8'hA1, 8'h09, 8'hF4, "R9", 1'b1, 1'b0);
    xfer(8'hA1, 8'h80, 8'h75, "R6", 1'b1, 1'b0);
    xfer(8'hA0, 8'h03, 8'h00, "R7", 1'b1, 1'b0);
    xfer(8'hA1, 8'h00, 8'h0D, "R8", 1'b1, 1'b0);

    // R3: restart after a partial command
    pin(1'b1, 1'b0, 1'b0, "R3");
    pin(1'b0, 1'b1, 1'b1, "R3");
    pin(1'b1, 1'b1, 1'b1, "R3");
    pin(1'b0, 1'b0, 1'b0, "R3");
    pin(1'b1, 1'b0, 1'b0, "R3");
    pin(1'b0, 1'b1, 1'b1, "R3");
    pin(1'b1, 1'b1, 1'b1, "R3");
    pin(1'b1, 1'b0, 1'b0, "R3");
    xfer(8'hA1, 8'h3E, 8'h80, "R3", 1'b0, 1'b0);
    xfer(8'hA1, 8'h02, 8'h12, "R9", 1'b1, 1'b0);

    // R5: skewed edges inserted before every command bit
    xfer(8'hA1, 8'h00, 8'h04, "R5", 1'b1, 1'b1);
    xfer(8'hA1, 8'h00, 8'h80, "R6", 1'b1, 1'b0);

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL queue pending=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule